// File: doc/BRIEF.md
# Integer Outer-Product Accumulate Unit

This unit performs one rank-k integer outer-product update on a 4x4 array of 32-bit accumulator words held inside the block. Each request carries two 128-bit operands, A and B. Each operand is split into four 32-bit words. Accumulator entry (i,j) is formed from word i of A and word j of B. In byte mode each entry gets a rank-4 update: four byte products are summed, with A's bytes taken as signed and B's bytes as unsigned. In halfword mode each entry gets a rank-2 update: two products of signed halfwords are summed. All arithmetic is carried at 64-bit precision. The result is then reduced to 32 bits, either by truncation or by signed saturation.

A request enters through a valid/ready handshake. It is accepted on any cycle where `in_valid` and `in_ready` are both high. `in_ready` is low while reset is applied and during the first cycle after it. After that, `in_ready` stays high, because each accepted request updates all sixteen entries in a single cycle. A sender therefore never meets back-pressure after reset: it may hold `in_valid` high on consecutive cycles, and each such cycle is a separate request. `done` pulses one cycle after each acceptance. Per-row, per-column and per-product masks restrict the update. Any entry can be read at any time through a combinational read port.

Top module: `iopa_unit`

## Requirements
- R1: Accumulator entry (i,j) pairs A word i (`op_a[32i+31:32i]`) with B word j (`op_b[32j+31:32j]`). In byte mode (`elem_mode`=0) the entry sum is the total over k=0..3 of sext(A byte k) times zext(B byte k), where byte k is bits `[8k+7:8k]` of the word.
- R2: In halfword mode (`elem_mode`=1) the entry sum is the total over k=0..1 of sext(A halfword k) times sext(B halfword k), where halfword k is bits `[16k+15:16k]` of the word.
- R3: `op_sel`=0 writes the low 32 bits of the 64-bit entry sum.
- R4: `op_sel`=1 adds the sign-extended old entry to the sum at 64 bits and writes the low 32 bits, so the result wraps.
- R5: `op_sel`=2 adds the sign-extended old entry to the sum and writes the result clamped to the range 0x80000000..0x7FFFFFFF.
- R6: `op_sel`=3 writes the sum alone, clamped to the same signed 32-bit range, ignoring the old entry.
- R7: An entry whose `row_mask[i]` or `col_mask[j]` is 0 is written as zero by an accepted request, whatever `op_sel` is.
- R8: `prod_mask[k]`=0 removes product k from the sum. In halfword mode only `prod_mask[1:0]` take part; bits 3:2 have no effect.
- R9: A request is accepted when `in_valid` and `in_ready` are both high. `done` is high in exactly the cycle after an acceptance. Without an acceptance, no entry changes.
- R10: A synchronous reset clears all entries and `done`, and holds `in_ready` low. Reset takes priority over a request presented in the same cycle.
- R11: `rd_data` shows entry (`rd_row`,`rd_col`) combinationally. An update becomes visible only after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| elem_mode | input | 1 | 0 = byte elements (rank 4), 1 = halfword elements (rank 2) |
| op_sel | input | 2 | 0 overwrite, 1 wrapping accumulate, 2 saturating accumulate, 3 saturating overwrite |
| op_a | input | 128 | Row operand, four 32-bit words |
| op_b | input | 128 | Column operand, four 32-bit words |
| row_mask | input | 4 | Enable for each accumulator row |
| col_mask | input | 4 | Enable for each accumulator column |
| prod_mask | input | 4 | Enable for each product within an entry |
| done | output | 1 | Pulses one cycle after acceptance |
| rd_row | input | 2 | Read row index |
| rd_col | input | 2 | Read column index |
| rd_data | output | 32 | Selected accumulator entry |

## Verification
Two activities can fall in the same cycle. The first is a read of an entry while a request that rewrites that entry is being accepted. The bench presents an accumulate request with the read port aimed at entry (0,0). It requires the old value before the edge and the new value after it. The second is a reset that arrives together with a valid request. The bench raises both in one cycle and requires a cleared array, no `done` pulse and a low `in_ready` afterwards.

// File: rtl/iopa_pkg.sv
package iopa_pkg;

  typedef enum logic {
    ELEM_B8  = 1'b0,
    ELEM_H16 = 1'b1
  } elem_mode_e;

  typedef enum logic [1:0] {
    OP_SET      = 2'd0,
    OP_ADD_WRAP = 2'd1,
    OP_ADD_SAT  = 2'd2,
    OP_SET_SAT  = 2'd3
  } acc_op_e;

endpackage

// File: rtl/iopa_dot.sv
// Per-entry dot product: byte (rank 4, signed x unsigned) or halfword (rank 2, signed x signed)
module iopa_dot
  import iopa_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WIDE_W = 64,
  localparam int NB = WORD_W / 8,
  localparam int NH = WORD_W / 16
) (
  input  logic [WORD_W-1:0]        a_word,
  input  logic [WORD_W-1:0]        b_word,
  input  elem_mode_e               mode,
  input  logic [NB-1:0]            prod_mask,
  output logic signed [WIDE_W-1:0] dot_sum
);

  logic signed [WIDE_W-1:0] bprod [NB];
  logic signed [WIDE_W-1:0] hprod [NH];
  logic signed [WIDE_W-1:0] b_total;
  logic signed [WIDE_W-1:0] h_total;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic signed [WIDE_W-1:0] a_ext;
    logic signed [WIDE_W-1:0] b_ext;
    assign a_ext = {{(WIDE_W-8){a_word[8*k+7]}}, a_word[8*k +: 8]};
    assign b_ext = {{(WIDE_W-8){1'b0}}, b_word[8*k +: 8]};
    assign bprod[k] = prod_mask[k] ? (a_ext * b_ext) : '0;
  end

  for (genvar k = 0; k < NH; k++) begin : g_half
    logic signed [WIDE_W-1:0] a_ext;
    logic signed [WIDE_W-1:0] b_ext;
    assign a_ext = {{(WIDE_W-16){a_word[16*k+15]}}, a_word[16*k +: 16]};
    assign b_ext = {{(WIDE_W-16){b_word[16*k+15]}}, b_word[16*k +: 16]};
    assign hprod[k] = prod_mask[k] ? (a_ext * b_ext) : '0;
  end

  always_comb begin
    b_total = '0;
    for (int k = 0; k < NB; k++) b_total = b_total + bprod[k];
  end

  always_comb begin
    h_total = '0;
    for (int k = 0; k < NH; k++) h_total = h_total + hprod[k];
  end

  assign dot_sum = (mode == ELEM_H16) ? h_total : b_total;

endmodule

// File: rtl/iopa_fold.sv
// Reduces a wide entry sum to one accumulator word per the operation select
module iopa_fold
  import iopa_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WIDE_W = 64
) (
  input  logic signed [WIDE_W-1:0] dot_sum,
  input  logic [WORD_W-1:0]        old_word,
  input  acc_op_e                  op,
  input  logic                     entry_en,
  output logic [WORD_W-1:0]        new_word
);

  localparam logic signed [WIDE_W-1:0] SAT_HI =
    {{(WIDE_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] SAT_LO =
    {{(WIDE_W-WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};

  logic signed [WIDE_W-1:0] old_ext;
  logic signed [WIDE_W-1:0] acc_sum;
  logic signed [WIDE_W-1:0] sat_src;
  logic [WORD_W-1:0]        sat_word;

  assign old_ext = {{(WIDE_W-WORD_W){old_word[WORD_W-1]}}, old_word};
  assign acc_sum = dot_sum + old_ext;
  assign sat_src = (op == OP_SET_SAT) ? dot_sum : acc_sum;

  always_comb begin
    if (sat_src > SAT_HI)      sat_word = SAT_HI[WORD_W-1:0];
    else if (sat_src < SAT_LO) sat_word = SAT_LO[WORD_W-1:0];
    else                       sat_word = sat_src[WORD_W-1:0];
  end

  always_comb begin
    if (!entry_en) begin
      new_word = '0;
    end else begin
      unique case (op)
        OP_SET:      new_word = dot_sum[WORD_W-1:0];
        OP_ADD_WRAP: new_word = acc_sum[WORD_W-1:0];
        default:     new_word = sat_word;
      endcase
    end
  end

endmodule

// File: rtl/iopa_acc_bank.sv
// Accumulator storage: all entries written together, one combinational read port
module iopa_acc_bank #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int WORD_W = 32,
  localparam int N  = ROWS * COLS,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [N*WORD_W-1:0]   wr_data,
  input  logic [RW-1:0]         rd_row,
  input  logic [CW-1:0]         rd_col,
  output logic [WORD_W-1:0]     rd_data,
  output logic [N*WORD_W-1:0]   acc_flat
);

  logic [WORD_W-1:0] entry_q [N];

  for (genvar e = 0; e < N; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)        entry_q[e] <= '0;
      else if (wr_en) entry_q[e] <= wr_data[e*WORD_W +: WORD_W];
    end
    assign acc_flat[e*WORD_W +: WORD_W] = entry_q[e];
  end

  always_comb begin
    int unsigned idx;
    idx = int'(rd_row) * COLS + int'(rd_col);
    rd_data = '0;
    if (idx < N) rd_data = entry_q[idx];
  end

endmodule

// File: rtl/iopa_unit.sv
// Integer outer-product accumulate unit (top)
module iopa_unit
  import iopa_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int WORD_W = 32,
  parameter int WIDE_W = 64,
  localparam int NB = WORD_W / 8,
  localparam int N  = ROWS * COLS,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     elem_mode,
  input  logic [1:0]               op_sel,
  input  logic [ROWS*WORD_W-1:0]   op_a,
  input  logic [COLS*WORD_W-1:0]   op_b,
  input  logic [ROWS-1:0]          row_mask,
  input  logic [COLS-1:0]          col_mask,
  input  logic [NB-1:0]            prod_mask,
  output logic                     done,
  input  logic [RW-1:0]            rd_row,
  input  logic [CW-1:0]            rd_col,
  output logic [WORD_W-1:0]        rd_data
);

  logic                  ready_q;
  logic                  done_q;
  logic                  accept;
  elem_mode_e            mode;
  acc_op_e               op;
  logic [N*WORD_W-1:0]   acc_flat;
  logic [N*WORD_W-1:0]   next_flat;

  assign mode   = elem_mode_e'(elem_mode);
  assign op     = acc_op_e'(op_sel);
  assign accept = in_valid && ready_q && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      done_q  <= accept;
    end
  end

  assign in_ready = ready_q;
  assign done     = done_q;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    for (genvar j = 0; j < COLS; j++) begin : g_col
      localparam int E = i * COLS + j;
      logic signed [WIDE_W-1:0] sum;

      iopa_dot #(.WORD_W(WORD_W), .WIDE_W(WIDE_W)) u_dot (
        .a_word    (op_a[i*WORD_W +: WORD_W]),
        .b_word    (op_b[j*WORD_W +: WORD_W]),
        .mode      (mode),
        .prod_mask (prod_mask),
        .dot_sum   (sum)
      );

      iopa_fold #(.WORD_W(WORD_W), .WIDE_W(WIDE_W)) u_fold (
        .dot_sum  (sum),
        .old_word (acc_flat[E*WORD_W +: WORD_W]),
        .op       (op),
        .entry_en (row_mask[i] && col_mask[j]),
        .new_word (next_flat[E*WORD_W +: WORD_W])
      );
    end
  end

  iopa_acc_bank #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (accept),
    .wr_data  (next_flat),
    .rd_row   (rd_row),
    .rd_col   (rd_col),
    .rd_data  (rd_data),
    .acc_flat (acc_flat)
  );

endmodule

// File: rtl/iopa_unit_chk.sv
module iopa_unit_chk #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int WORD_W = 32,
  localparam int N = ROWS * COLS
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic                done,
  input logic [ROWS-1:0]     row_mask,
  input logic [COLS-1:0]     col_mask,
  input logic [N*WORD_W-1:0] acc_flat
);

  logic take;
  logic rst_seen;
  assign take = in_valid && in_ready;

  always_ff @(posedge clk) rst_seen <= rst;

  // R9
  done_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> done);

  // R9
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> !done);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(acc_flat));

  // R10
  always @(negedge clk) begin
    if (rst_seen === 1'b1) begin
      reset_clear_chk: assert (acc_flat == '0 && !done && !in_ready);
    end
  end

  for (genvar i = 0; i < ROWS; i++) begin : g_r
    for (genvar j = 0; j < COLS; j++) begin : g_c
      // R7
      masked_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !(row_mask[i] && col_mask[j]))
          |=> acc_flat[(i*COLS+j)*WORD_W +: WORD_W] == '0);
    end
  end

endmodule

bind iopa_unit iopa_unit_chk #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .done     (done),
  .row_mask (row_mask),
  .col_mask (col_mask),
  .acc_flat (acc_flat)
);

// File: tb/iopa_unit_test.sv
`timescale 1ns/1ps
module iopa_unit_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         elem_mode = 1'b0;
  logic [1:0]   op_sel = 2'd0;
  logic [127:0] op_a = '0;
  logic [127:0] op_b = '0;
  logic [3:0]   row_mask = 4'hF;
  logic [3:0]   col_mask = 4'hF;
  logic [3:0]   prod_mask = 4'hF;
  logic         done;
  logic [1:0]   rd_row = 2'd0;
  logic [1:0]   rd_col = 2'd0;
  logic [31:0]  rd_data;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] exp_acc [16];

  always #2.5 clk = ~clk;

  iopa_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .elem_mode(elem_mode), .op_sel(op_sel), .op_a(op_a), .op_b(op_b),
    .row_mask(row_mask), .col_mask(col_mask), .prod_mask(prod_mask),
    .done(done), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] clamp32(input longint v);
    if (v > 64'sd2147483647) return 32'h7FFFFFFF;
    if (v < -64'sd2147483648) return 32'h80000000;
    return v[31:0];
  endfunction

  function automatic logic [31:0] model_entry(input logic [31:0] aw, input logic [31:0] bw,
      input logic mode, input logic [1:0] op, input logic en, input logic [3:0] pm,
      input logic [31:0] old);
    longint s = 0;
    longint o;
    longint t;
    if (!en) return 32'h0;
    if (!mode) begin
      for (int k = 0; k < 4; k++) begin
        longint av = $signed(aw[8*k +: 8]);
        longint bv = {56'd0, bw[8*k +: 8]};
        if (pm[k]) s = s + av * bv;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        longint av = $signed(aw[16*k +: 16]);
        longint bv = $signed(bw[16*k +: 16]);
        if (pm[k]) s = s + av * bv;
      end
    end
    o = $signed(old);
    case (op)
      2'd0: return s[31:0];
      2'd1: begin t = s + o; return t[31:0]; end
      2'd2: return clamp32(s + o);
      default: return clamp32(s);
    endcase
  endfunction

  task automatic update_model();
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        exp_acc[i*4+j] = model_entry(op_a[32*i +: 32], op_b[32*j +: 32], elem_mode, op_sel,
                                     row_mask[i] && col_mask[j], prod_mask, exp_acc[i*4+j]);
  endtask

  task automatic check_all(input string req);
    for (int e = 0; e < 16; e++) begin
      rd_row = 2'(e / 4);
      rd_col = 2'(e % 4);
      #0.1;
      check(rd_data === exp_acc[e], req, rd_data, exp_acc[e]);
    end
  endtask

  task automatic read_entry(input int e, output logic [31:0] v);
    rd_row = 2'(e / 4);
    rd_col = 2'(e % 4);
    #0.1;
    v = rd_data;
  endtask

  task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic mode,
      input logic [1:0] op, input logic [3:0] rm, input logic [3:0] cm, input logic [3:0] pm,
      input string req);
    @(negedge clk);
    op_a = a; op_b = b; elem_mode = mode; op_sel = op;
    row_mask = rm; col_mask = cm; prod_mask = pm;
    in_valid = 1'b1;
    update_model();
    @(negedge clk);
    in_valid = 1'b0;
    check(done === 1'b1, "R9 done after accept", {31'd0, done}, 32'd1);
    check_all(req);
    @(negedge clk);
    check(done === 1'b0, "R9 done single pulse", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset();
    for (int e = 0; e < 16; e++) exp_acc[e] = '0;
    repeat (3) @(negedge clk);
    check(in_ready === 1'b0, "R10 ready low in reset", {31'd0, in_ready}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready === 1'b1, "R9 ready after reset", {31'd0, in_ready}, 32'd1);
    check(done === 1'b0, "R10 done clear", {31'd0, done}, 32'd0);
    check_all("R10 reset clears");
  endtask

  task automatic t_byte_sign();
    logic [31:0] v;
    run_op({4{32'h000000FF}}, {4{32'h000000FF}}, 1'b0, 2'd0, 4'hF, 4'hF, 4'hF, "R1 byte sign");
    read_entry(5, v);
    check(v === 32'hFFFFFF01, "R1 signed A x unsigned B", v, 32'hFFFFFF01);
    run_op(128'h80FF7F01_12345678_FEDCBA98_01020304, 128'hFF80017F_A5A55A5A_00FF00FF_7F7F8080,
           1'b0, 2'd0, 4'hF, 4'hF, 4'hF, "R1 byte mix");
  endtask

  task automatic t_half_overwrite();
    logic [31:0] v;
    run_op({4{32'h80008000}}, {4{32'h80008000}}, 1'b1, 2'd0, 4'hF, 4'hF, 4'hF, "R3 wrap overflow");
    read_entry(0, v);
    check(v === 32'h80000000, "R3 low 32 bits", v, 32'h80000000);
    run_op(128'h7FFF8000_0001FFFF_1234ABCD_80007FFF, 128'hFFFF0002_8000_8000_00030004_7FFF7FFF,
           1'b1, 2'd0, 4'hF, 4'hF, 4'hF, "R2 halfword mix");
  endtask

  task automatic t_sat_overwrite();
    logic [31:0] v;
    run_op({4{32'h80008000}}, {4{32'h80008000}}, 1'b1, 2'd3, 4'hF, 4'hF, 4'hF, "R6 sat set");
    read_entry(10, v);
    check(v === 32'h7FFFFFFF, "R6 clamp high", v, 32'h7FFFFFFF);
  endtask

  task automatic t_read_during_update();
    logic [31:0] v;
    logic [31:0] old0;
    old0 = exp_acc[0];
    @(negedge clk);
    op_a = {4{32'h00010001}}; op_b = {4{32'h00010001}}; elem_mode = 1'b1; op_sel = 2'd1;
    row_mask = 4'hF; col_mask = 4'hF; prod_mask = 4'hF;
    in_valid = 1'b1;
    update_model();
    read_entry(0, v);
    check(v === old0, "R11 old value before edge", v, old0);
    @(negedge clk);
    in_valid = 1'b0;
    read_entry(0, v);
    check(v === 32'h80000001, "R4 wrap accumulate", v, 32'h80000001);
    check_all("R11 new value after edge");
  endtask

  task automatic t_sat_accumulate();
    logic [31:0] v;
    run_op({4{32'h80008000}}, {4{32'h7FFF7FFF}}, 1'b1, 2'd0, 4'hF, 4'hF, 4'hF, "R3 setup");
    run_op({4{32'h80008000}}, {4{32'h7FFF7FFF}}, 1'b1, 2'd2, 4'hF, 4'hF, 4'hF, "R5 sat low");
    read_entry(3, v);
    check(v === 32'h80000000, "R5 clamp low", v, 32'h80000000);
    run_op(128'h01020304_FFFEFDFC_7F7F7F7F_80808080, 128'hFFFFFFFF_01010101_80808080_7F7F7F7F,
           1'b0, 2'd2, 4'hF, 4'hF, 4'hF, "R5 byte sat acc");
    run_op(128'h01020304_FFFEFDFC_7F7F7F7F_80808080, 128'hFFFFFFFF_01010101_80808080_7F7F7F7F,
           1'b0, 2'd1, 4'hF, 4'hF, 4'hF, "R4 byte wrap acc");
  endtask

  task automatic t_masks();
    run_op(128'h11223344_55667788_99AABBCC_DDEEFF00, 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0,
           1'b0, 2'd1, 4'b0101, 4'b0110, 4'hF, "R7 row col mask");
    run_op(128'h7FFF0001_00020003_80008000_12341234, {4{32'h00050007}},
           1'b1, 2'd2, 4'b1110, 4'b1011, 4'hF, "R7 mask sat acc");
  endtask

  task automatic t_prod_mask();
    logic [31:0] va;
    logic [31:0] vb;
    run_op(128'h80FF7F01_12345678_FEDCBA98_01020304, 128'hFF80017F_A5A55A5A_00FF00FF_7F7F8080,
           1'b0, 2'd0, 4'hF, 4'hF, 4'b0010, "R8 byte product mask");
    run_op(128'h7FFF8000_0001FFFF_1234ABCD_80007FFF, {4{32'h00030004}},
           1'b1, 2'd0, 4'hF, 4'hF, 4'b1101, "R8 half mask bits");
    read_entry(7, va);
    run_op(128'h7FFF8000_0001FFFF_1234ABCD_80007FFF, {4{32'h00030004}},
           1'b1, 2'd0, 4'hF, 4'hF, 4'b0001, "R8 half mask low only");
    read_entry(7, vb);
    check(va === vb, "R8 upper bits ignored in halfword mode", va, vb);
  endtask

  task automatic t_idle_hold();
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      op_a = {4{32'hDEADBEEF}} ^ {96'd0, 32'(c)};
      op_b = {4{32'h0BADF00D}};
      op_sel = 2'(c);
      elem_mode = c[0];
      check(done === 1'b0, "R9 no done when idle", {31'd0, done}, 32'd0);
    end
    @(negedge clk);
    check_all("R9 idle hold");
  endtask

  task automatic t_reset_vs_valid();
    @(negedge clk);
    rst = 1'b1;
    op_a = {4{32'h01010101}}; op_b = {4{32'h01010101}}; elem_mode = 1'b0; op_sel = 2'd0;
    row_mask = 4'hF; col_mask = 4'hF; prod_mask = 4'hF;
    in_valid = 1'b1;
    for (int e = 0; e < 16; e++) exp_acc[e] = '0;
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    check(done === 1'b0, "R10 reset beats request", {31'd0, done}, 32'd0);
    check(in_ready === 1'b0, "R10 ready low after reset cycle", {31'd0, in_ready}, 32'd0);
    check_all("R10 reset beats request");
    @(negedge clk);
    check(in_ready === 1'b1, "R9 ready returns", {31'd0, in_ready}, 32'd1);
  endtask

  initial begin
    t_reset();
    t_byte_sign();
    t_half_overwrite();
    t_sat_overwrite();
    t_read_during_update();
    t_sat_accumulate();
    t_masks();
    t_prod_mask();
    t_idle_hold();
    t_reset_vs_valid();
    run_op({4{32'h00020003}}, {4{32'hFFFF0004}}, 1'b1, 2'd1, 4'hF, 4'hF, 4'hF, "R4 after reset");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule